// File: doc/BRIEF.md
# CAN Interrupt Request Aggregator

This block gathers every interrupt cause of a CAN controller into one shared request. Each of the sixteen message slots reports a transmit-complete or a receive-complete pulse. The controller separately reports bus-error detection, entry into error-passive and entry into bus-off. Every cause sets a sticky status bit. Each status bit has its own mask bit. The masked status bits are ORed into one combined request.

A rising edge of the combined request sets three request flags together, one for each interrupt-controller line. Each flag drives a pending output, but only while at least one of the three line enables is set. Software reaches the status bits, masks, flags and enables through a small write port. Status bits and flags are cleared by writing 1 to them. No hardware event ever clears them, and neither does an interrupt acknowledge.

While the combined request stays high, no new edge can occur, so further causes produce no new request. To re-arm the block, software must clear every enabled status bit and the flags.

Top module: `can_irq_aggr`

## Requirements
- R1: A transmit-complete or receive-complete pulse on slot k sets slot status bit k (`slot_sts_o[k]`) on the next clock edge.
- R2: The error status bits are: bit 0 for a bus error, bit 1 for error-passive entry and bit 2 for bus-off entry. Each is set on the edge after its pulse.
- R3: A bus-error pulse sets the bus-error state flag and error status bit 0 on the same edge.
- R4: A write with `wr_en_i` high clears, at each position where the data bit is 1, the bits of the addressed register:
  - address 0: slot status;
  - address 1: error status bits 2:0, with data bit 3 clearing the bus-error state flag;
  - address 4: request flags.
  If a set event and a clear meet on one bit in the same cycle, the bit ends up set.
- R5: Address 2 loads the slot mask, address 3 loads the error mask (bits 2:0) and address 5 loads the line enables (bits 2:0). The combined request is the OR of all status bits ANDed with their mask bits. On the edge after the combined request goes from 0 to 1, all three request flags become 1.
- R6: `irq_o[k]` equals request flag k when any line enable is set, and is 0 when all enables are 0.
- R7: While the combined request stays 1, new masked causes leave the flags and `irq_o` unchanged. After the flags alone are cleared, they stay 0 until the status bits are cleared and a new cause arrives.
- R8: Status bits and flags stay set over any number of idle cycles, until software clears them.
- R9: After reset, all status bits, masks, enables, flags, the state flag and the pending outputs are 0.
- R10: A cause whose mask bit is 0 sets its status bit but does not raise the request flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| slot_tx_done_i | input | 16 | Per-slot transmit-complete pulses |
| slot_rx_done_i | input | 16 | Per-slot receive-complete pulses |
| bus_err_i | input | 1 | Bus-error detected pulse |
| err_passive_i | input | 1 | Error-passive entry pulse |
| bus_off_i | input | 1 | Bus-off entry pulse |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register select |
| wr_data_i | input | 16 | Write data or clear mask |
| slot_sts_o | output | 16 | Sticky slot status |
| err_sts_o | output | 3 | Sticky error status |
| bus_err_state_o | output | 1 | Sticky bus-error state flag |
| req_flag_o | output | 3 | Request flags, one per line |
| irq_o | output | 3 | Pending outputs to the interrupt controller |

## Verification
The hardest situation to reach is the hidden request. The combined request is already high and a fresh cause arrives, or software clears only the flags while an enabled status bit is still set. In both cases nothing may change. The stimulus first raises a request, then pulses another unmasked slot and checks that the flags hold. It then clears the flags alone and watches them stay 0 for several cycles. Finally it clears the slot status, sends a new cause and checks that a new edge sets all three flags again. A separate scenario drives a slot event and its clear in the same cycle to show that the set wins.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;
  localparam int unsigned N_ERR  = 3;
  localparam int unsigned N_LINE = 3;
  localparam int unsigned AW     = 3;
  localparam int unsigned STATE_CLR_BIT = 3;

  typedef enum logic [AW-1:0] {
    A_SLOT_CLR = 3'd0,
    A_ERR_CLR  = 3'd1,
    A_SLOT_MSK = 3'd2,
    A_ERR_MSK  = 3'd3,
    A_FLAG_CLR = 3'd4,
    A_LINE_EN  = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/can_irq_sts.sv
module can_irq_sts #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] sts_o
);
  logic [W-1:0] sts_q;

  // set has priority over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_q <= '0;
    else         sts_q <= (sts_q & ~clr_i) | set_i;
  end

  assign sts_o = sts_q;

  // R1 R2 R4: every pulsed bit is set afterwards, even with a clear
  p_set_sticks_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((sts_q & $past(set_i)) == $past(set_i)));

  // R8: no bit falls without a software clear
  p_no_hw_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sts_q & ~clr_i) != '0) |=> (($past(sts_q) & ~$past(clr_i) & ~sts_q) == '0));
endmodule

// File: rtl/can_irq_req.sv
module can_irq_req
  import can_irq_pkg::*;
#(
  parameter int unsigned NSLOT = 16,
  parameter int unsigned DW    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSLOT-1:0]  slot_sts_i,
  input  logic [N_ERR-1:0]  err_sts_i,
  input  logic              wr_en_i,
  input  reg_addr_e         wr_addr_i,
  input  logic [DW-1:0]     wr_data_i,
  output logic [N_LINE-1:0] flag_o,
  output logic [N_LINE-1:0] irq_o
);
  logic [NSLOT-1:0]  slot_msk_q;
  logic [N_ERR-1:0]  err_msk_q;
  logic [N_LINE-1:0] en_q, flag_q, flag_clr;
  logic              comb_req, comb_q, rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_msk_q <= '0;
      err_msk_q  <= '0;
      en_q       <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == A_SLOT_MSK) slot_msk_q <= wr_data_i[NSLOT-1:0];
      if (wr_addr_i == A_ERR_MSK)  err_msk_q  <= wr_data_i[N_ERR-1:0];
      if (wr_addr_i == A_LINE_EN)  en_q       <= wr_data_i[N_LINE-1:0];
    end
  end

  assign comb_req = (|(slot_sts_i & slot_msk_q)) | (|(err_sts_i & err_msk_q));
  assign rise     = comb_req & ~comb_q;
  assign flag_clr = (wr_en_i && wr_addr_i == A_FLAG_CLR) ? wr_data_i[N_LINE-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      comb_q <= 1'b0;
      flag_q <= '0;
    end else begin
      comb_q <= comb_req;
      flag_q <= (flag_q & ~flag_clr) | {N_LINE{rise}};
    end
  end

  assign flag_o = flag_q;

  for (genvar k = 0; k < N_LINE; k++) begin : g_line
    assign irq_o[k] = flag_q[k] & (|en_q);
  end

  // R5: a fresh rise of the combined request sets every flag
  p_rise_sets_all_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (comb_req && !comb_q) |=> (&flag_q));

  // R7: with the request held high and no clear, flags do not move
  p_no_new_edge_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (comb_q && comb_req && flag_clr == '0) |=> $stable(flag_q));

  // R6: pending outputs need an enabled line
  p_irq_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o != '0) |-> (en_q != '0));
endmodule

// File: rtl/can_irq_aggr.sv
module can_irq_aggr
  import can_irq_pkg::*;
#(
  parameter int unsigned NSLOT = 16,
  parameter int unsigned DW    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSLOT-1:0]  slot_tx_done_i,
  input  logic [NSLOT-1:0]  slot_rx_done_i,
  input  logic              bus_err_i,
  input  logic              err_passive_i,
  input  logic              bus_off_i,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [DW-1:0]     wr_data_i,
  output logic [NSLOT-1:0]  slot_sts_o,
  output logic [N_ERR-1:0]  err_sts_o,
  output logic              bus_err_state_o,
  output logic [N_LINE-1:0] req_flag_o,
  output logic [N_LINE-1:0] irq_o
);
  reg_addr_e        addr;
  logic [NSLOT-1:0] slot_clr;
  logic [N_ERR-1:0] err_clr;
  logic             state_clr;

  assign addr      = reg_addr_e'(wr_addr_i);
  assign slot_clr  = (wr_en_i && addr == A_SLOT_CLR) ? wr_data_i[NSLOT-1:0] : '0;
  assign err_clr   = (wr_en_i && addr == A_ERR_CLR)  ? wr_data_i[N_ERR-1:0] : '0;
  assign state_clr = wr_en_i && addr == A_ERR_CLR && wr_data_i[STATE_CLR_BIT];

  can_irq_sts #(.W(NSLOT)) u_slot_sts (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (slot_tx_done_i | slot_rx_done_i),
    .clr_i (slot_clr),
    .sts_o (slot_sts_o)
  );

  can_irq_sts #(.W(N_ERR)) u_err_sts (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i ({bus_off_i, err_passive_i, bus_err_i}),
    .clr_i (err_clr),
    .sts_o (err_sts_o)
  );

  can_irq_sts #(.W(1)) u_state (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (bus_err_i),
    .clr_i (state_clr),
    .sts_o (bus_err_state_o)
  );

  can_irq_req #(.NSLOT(NSLOT), .DW(DW)) u_req (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .slot_sts_i(slot_sts_o),
    .err_sts_i (err_sts_o),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (addr),
    .wr_data_i (wr_data_i),
    .flag_o    (req_flag_o),
    .irq_o     (irq_o)
  );

  // R3: a bus error shows in the state flag and status bit 0 together
  p_buserr_same_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_err_i |=> (bus_err_state_o && err_sts_o[0]));
endmodule

// File: tb/sim_can_irq_aggr.sv
module sim_can_irq_aggr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] tx = '0, rx = '0, wdata = '0;
  logic        berr = 0, pasv = 0, boff = 0, wen = 0;
  logic [2:0]  waddr = '0;
  logic [15:0] slot_sts;
  logic [2:0]  err_sts, flag, irq;
  logic        bstate;
  int          n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  can_irq_aggr u0 (
    .clk_i(clk), .rst_ni(rst_n), .slot_tx_done_i(tx), .slot_rx_done_i(rx),
    .bus_err_i(berr), .err_passive_i(pasv), .bus_off_i(boff),
    .wr_en_i(wen), .wr_addr_i(waddr), .wr_data_i(wdata),
    .slot_sts_o(slot_sts), .err_sts_o(err_sts), .bus_err_state_o(bstate),
    .req_flag_o(flag), .irq_o(irq)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    waddr = a; wdata = d; wen = 1'b1;
    tick();
    wen = 1'b0; wdata = '0;
  endtask

  task automatic pulse_tx(input logic [15:0] m);
    tx = m; tick(); tx = '0;
  endtask

  task automatic pulse_rx(input logic [15:0] m);
    rx = m; tick(); rx = '0;
  endtask

  task automatic clear_all();
    wr(3'd0, 16'hFFFF);
    wr(3'd1, 16'h000F);
    wr(3'd4, 16'h0007);
    tick(2);
  endtask

  task automatic t_reset();
    check("R9", "slot_sts", slot_sts, 0);
    check("R9", "err_sts", err_sts, 0);
    check("R9", "state", bstate, 0);
    check("R9", "flag", flag, 0);
    check("R9", "irq", irq, 0);
  endtask

  task automatic t_slot_status();
    pulse_tx(16'h0008);
    pulse_rx(16'h1000);
    check("R1", "slot tx3 rx12", slot_sts, 32'h1008);
    tick(2);
    check("R10", "masked-off slots no flag", flag, 0);
    wr(3'd0, 16'h0008);
    check("R4", "w1c slot3", slot_sts, 32'h1000);
    clear_all();
  endtask

  task automatic t_error_status();
    berr = 1'b1; tick(); berr = 1'b0;
    check("R3", "state with bus error", bstate, 1);
    check("R2", "bus error bit0", err_sts, 32'h1);
    pasv = 1'b1; tick(); pasv = 1'b0;
    check("R2", "passive bit1", err_sts, 32'h3);
    boff = 1'b1; tick(); boff = 1'b0;
    check("R2", "bus-off bit2", err_sts, 32'h7);
    wr(3'd1, 16'h0002);
    check("R4", "w1c passive", err_sts, 32'h5);
    check("R4", "state kept", bstate, 1);
    wr(3'd1, 16'h0008);
    check("R4", "w1c state", bstate, 0);
    clear_all();
  endtask

  task automatic t_edge_and_hide();
    wr(3'd5, 16'h0001);
    wr(3'd2, 16'hFFFF);
    pulse_tx(16'h0001);
    check("R5", "flag not yet", flag, 0);
    tick();
    check("R5", "flags on rise", flag, 7);
    check("R6", "irq enabled", irq, 7);
    pulse_rx(16'h0020);
    tick(2);
    check("R7", "flags held on new cause", flag, 7);
    check("R7", "irq held on new cause", irq, 7);
    wr(3'd4, 16'h0007);
    check("R4", "w1c flags", flag, 0);
    tick(3);
    check("R7", "hidden while status set", flag, 0);
    tick(20);
    check("R8", "slot status sticky", slot_sts, 32'h0021);
    wr(3'd0, 16'hFFFF);
    pulse_tx(16'h0080);
    tick();
    check("R7", "re-armed after clear", flag, 7);
    clear_all();
  endtask

  task automatic t_enable_gate();
    wr(3'd5, 16'h0000);
    pulse_rx(16'h0100);
    tick();
    check("R6", "flags without enable", flag, 7);
    check("R6", "irq gated off", irq, 0);
    wr(3'd5, 16'h0004);
    check("R6", "irq after enable", irq, 7);
    tick(30);
    check("R8", "flags sticky", flag, 7);
    clear_all();
  endtask

  task automatic t_set_wins();
    tx = 16'h0004; waddr = 3'd0; wdata = 16'h0004; wen = 1'b1;
    tick();
    tx = '0; wen = 1'b0; wdata = '0;
    check("R4", "set beats clear", slot_sts, 32'h0004);
    clear_all();
  endtask

  task automatic t_error_mask();
    wr(3'd2, 16'h0000);
    wr(3'd3, 16'h0004);
    berr = 1'b1; tick(); berr = 1'b0;
    tick(2);
    check("R10", "masked bus error no flag", flag, 0);
    boff = 1'b1; tick(); boff = 1'b0;
    tick();
    check("R5", "bus-off raises flags", flag, 7);
    clear_all();
  endtask

  initial begin
    tick(2);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_slot_status();
    t_error_status();
    t_edge_and_hide();
    t_enable_gate();
    t_set_wins();
    t_error_mask();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule